// File: doc/BRIEF.md
# Sixteen-Bit ALU with Status Flag Update

This block is the execute-stage arithmetic unit of a small sixteen-bit processor core. It is purely combinational. From an operation select, two register operands, an 8-bit immediate field and the current status word, it produces three things: the result word, a write strobe for the destination register, and the next status word with its zero, negative and carry flags updated.

The operation set covers add, add with carry, subtract-style compare, negate, the bitwise and/or/xor/not, and three shifts: logical left, logical right and arithmetic right. These shifts come in register-count and immediate-count forms. The set also includes immediate add/and/or and two load-immediate forms. Immediate arithmetic and bitwise forms use the low four bits of the immediate field under fixed extension rules. The load forms use all eight bits. The register file read, the write-back and the decode of the instruction word into `opSel` are done by the surrounding core.

Inside, a small decode stage turns `opSel` into a packed strobe word (function, operand source, flag mode, carry use, write). A datapath consumes that word.

Top module: `alu_flag_unit`

## Requirements
- R1: Operation codes on `opSel` are: 0 add, 1 add-with-carry (adds status bit 3), 2 and, 3 or, 4 xor, 5 shift left, 6 shift right logical, 7 shift right arithmetic, 8 negate (0 - A), 9 not, 10 compare (A - B), 11 add-immediate, 12 and-immediate, 13 or-immediate, 14 shift-immediate, 15 arithmetic-shift-immediate, 16 load-low, 17 load-high. Add and add-with-carry produce the low 16 bits of the sum.
- R2: The status word holds Z at bit 2, C at bit 3 and N at bit 4. Arithmetic operations (codes 0, 1, 5 to 8, 10, 11, 14, 15) set Z when the 16-bit result is zero, set N to result bit 15, and set C to bit 16 of the 17-bit result. All status bits other than 2 to 4 pass through unchanged for every code.
- R3: Bitwise operations (codes 2, 3, 4, 9, 12, 13) update Z and N in the same way and keep C at its input value.
- R4: Compare outputs A - B and updates the flags, with C set when A < B. It deasserts `resWrite`. Negate sets C exactly when A is non-zero. Every code from 0 to 17 except compare asserts `resWrite`.
- R5: Register-count shifts use all of `opB` as the count. A count of 0 returns A with C cleared. For a left shift by n (1 to 16), C is A bit 16-n. For a right shift by n (1 to 16), C is A bit n-1.
- R6: A count of 17 or more gives result 0 and C 0 for the logical shifts. For the arithmetic right shift, any count of 16 or more gives all result bits equal to A bit 15, with C equal to A bit 15.
- R7: Add-immediate adds the low four immediate bits sign-extended from bit 3. A field of zero adds +8.
- R8: And-immediate and or-immediate use the low four immediate bits sign-extended from bit 3.
- R9: Shift-immediate shifts right when immediate bit 3 is 1 and left otherwise, by immediate bits [2:0], where 0 means 8. Arithmetic-shift-immediate shifts right arithmetically by immediate bits [3:0], where 0 means 16.
- R10: Load-low outputs the 8-bit immediate sign-extended to 16 bits. Load-high outputs the immediate as the upper byte above A bits [7:0]. Both leave the status word unchanged.
- R11: Codes 18 to 31 output 0, deassert `resWrite` and leave the status word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opSel | input | 5 | Operation code as listed in R1 |
| opA | input | 16 | First register operand |
| opB | input | 16 | Second register operand or shift count |
| immVal | input | 8 | Immediate field; low four bits for immediate ops, all eight for loads |
| statusIn | input | 16 | Current status word |
| result | output | 16 | Operation result |
| statusOut | output | 16 | Next status word |
| resWrite | output | 1 | Destination write strobe |

## Verification
The checker assumes that every input is a settled two-state value when the combinational outputs are compared, and that `opSel` may take any of its 32 values, reserved ones included. The bench draws operands and status words at random from a fixed seed. It keeps shift counts mostly in the range 0 to 19, so that the carry boundary near 16 is reached often, and it also draws full 16-bit counts now and then. The reserved codes are picked on purpose. Directed cases add the zero-field immediate mappings, a zero shift count, borrow on compare and carry-in on add.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;

  localparam int ZBIT = 2;
  localparam int CBIT = 3;
  localparam int NBIT = 4;

  typedef enum logic [4:0] {
    OP_ADD  = 5'd0,  OP_ADC  = 5'd1,  OP_AND  = 5'd2,  OP_OR   = 5'd3,
    OP_XOR  = 5'd4,  OP_SHL  = 5'd5,  OP_SHR  = 5'd6,  OP_SAR  = 5'd7,
    OP_NEG  = 5'd8,  OP_NOT  = 5'd9,  OP_CMP  = 5'd10, OP_ADDI = 5'd11,
    OP_ANDI = 5'd12, OP_ORI  = 5'd13, OP_SHI  = 5'd14, OP_SARI = 5'd15,
    OP_LDLO = 5'd16, OP_LDHI = 5'd17
  } opCode_e;

  typedef enum logic [3:0] {
    FN_ADD, FN_SUB, FN_AND, FN_OR, FN_XOR, FN_NOT,
    FN_SHL, FN_SHR, FN_SAR, FN_LDLO, FN_LDHI, FN_ZERO
  } funcSel_e;

  typedef enum logic [2:0] {
    BS_REG, BS_ADDIMM, BS_SEXTIMM, BS_CNT8, BS_CNT16
  } bSrc_e;

  typedef enum logic [1:0] {
    FM_NONE, FM_ARITH, FM_LOGIC
  } flagMode_e;

  typedef struct packed {
    funcSel_e  func;
    bSrc_e     bSrc;
    flagMode_e flagMode;
    logic      useCarry;
    logic      negMode;
    logic      writeRes;
  } aluStrobe_t;

endpackage

// File: rtl/alu_flag_ctrl.sv
module alu_flag_ctrl
  import alu_flag_pkg::*;
(
  input  logic [4:0]  opSel,
  input  logic        immDir,
  output aluStrobe_t  strobe
);

  always_comb begin
    strobe          = '0;
    strobe.func     = FN_ZERO;
    strobe.bSrc     = BS_REG;
    strobe.flagMode = FM_NONE;
    strobe.writeRes = 1'b1;
    case (opSel)
      OP_ADD:  begin strobe.func = FN_ADD; strobe.flagMode = FM_ARITH; end
      OP_ADC:  begin strobe.func = FN_ADD; strobe.flagMode = FM_ARITH; strobe.useCarry = 1'b1; end
      OP_AND:  begin strobe.func = FN_AND; strobe.flagMode = FM_LOGIC; end
      OP_OR:   begin strobe.func = FN_OR;  strobe.flagMode = FM_LOGIC; end
      OP_XOR:  begin strobe.func = FN_XOR; strobe.flagMode = FM_LOGIC; end
      OP_SHL:  begin strobe.func = FN_SHL; strobe.flagMode = FM_ARITH; end
      OP_SHR:  begin strobe.func = FN_SHR; strobe.flagMode = FM_ARITH; end
      OP_SAR:  begin strobe.func = FN_SAR; strobe.flagMode = FM_ARITH; end
      OP_NEG:  begin strobe.func = FN_SUB; strobe.flagMode = FM_ARITH; strobe.negMode = 1'b1; end
      OP_NOT:  begin strobe.func = FN_NOT; strobe.flagMode = FM_LOGIC; end
      OP_CMP:  begin strobe.func = FN_SUB; strobe.flagMode = FM_ARITH; strobe.writeRes = 1'b0; end
      OP_ADDI: begin strobe.func = FN_ADD; strobe.flagMode = FM_ARITH; strobe.bSrc = BS_ADDIMM; end
      OP_ANDI: begin strobe.func = FN_AND; strobe.flagMode = FM_LOGIC; strobe.bSrc = BS_SEXTIMM; end
      OP_ORI:  begin strobe.func = FN_OR;  strobe.flagMode = FM_LOGIC; strobe.bSrc = BS_SEXTIMM; end
      OP_SHI:  begin
        strobe.func     = immDir ? FN_SHR : FN_SHL;
        strobe.flagMode = FM_ARITH;
        strobe.bSrc     = BS_CNT8;
      end
      OP_SARI: begin strobe.func = FN_SAR; strobe.flagMode = FM_ARITH; strobe.bSrc = BS_CNT16; end
      OP_LDLO: strobe.func = FN_LDLO;
      OP_LDHI: strobe.func = FN_LDHI;
      default: strobe.writeRes = 1'b0;
    endcase
  end

endmodule

// File: rtl/alu_flag_dp.sv
module alu_flag_dp
  import alu_flag_pkg::*;
#(
  parameter int W    = 16,
  parameter int IMMW = 8
)(
  input  aluStrobe_t        strobe,
  input  logic [W-1:0]      opA,
  input  logic [W-1:0]      opB,
  input  logic [IMMW-1:0]   immVal,
  input  logic [W-1:0]      statusIn,
  output logic [W-1:0]      result,
  output logic [W-1:0]      statusOut
);

  localparam int NIB = 4;
  localparam int LOW = W - IMMW;

  logic [W-1:0] immSext;
  logic [W-1:0] bVal;
  logic [W:0]   addRes;
  logic [W:0]   subRes;
  logic [W:0]   shlExt;
  logic [W:0]   shrExt;
  logic [W:0]   sarExt;
  logic [W:0]   fullRes;
  logic [W-1:0] subX;
  logic [W-1:0] subY;
  logic         cFlag;

  assign immSext = {{(W-NIB){immVal[NIB-1]}}, immVal[NIB-1:0]};

  always_comb begin
    case (strobe.bSrc)
      BS_ADDIMM:  bVal = (immVal[NIB-1:0] == '0) ? W'(8) : immSext;
      BS_SEXTIMM: bVal = immSext;
      BS_CNT8:    bVal = (immVal[NIB-2:0] == '0) ? W'(8) : W'(immVal[NIB-2:0]);
      BS_CNT16:   bVal = (immVal[NIB-1:0] == '0) ? W'(16) : W'(immVal[NIB-1:0]);
      default:    bVal = opB;
    endcase
  end

  assign subX   = strobe.negMode ? '0 : opA;
  assign subY   = strobe.negMode ? opA : bVal;
  assign addRes = {1'b0, opA} + {1'b0, bVal} + {{W{1'b0}}, strobe.useCarry & statusIn[CBIT]};
  assign subRes = {1'b0, subX} - {1'b0, subY};
  assign shlExt = {1'b0, opA} << bVal;
  assign shrExt = {opA, 1'b0} >> bVal;
  assign sarExt = $signed({opA, 1'b0}) >>> bVal;

  always_comb begin
    fullRes = '0;
    cFlag   = statusIn[CBIT];
    case (strobe.func)
      FN_ADD:  begin fullRes = addRes; cFlag = addRes[W]; end
      FN_SUB:  begin fullRes = subRes; cFlag = subRes[W]; end
      FN_AND:  fullRes[W-1:0] = opA & bVal;
      FN_OR:   fullRes[W-1:0] = opA | bVal;
      FN_XOR:  fullRes[W-1:0] = opA ^ bVal;
      FN_NOT:  fullRes[W-1:0] = ~opA;
      FN_SHL:  begin fullRes = shlExt; cFlag = shlExt[W]; end
      FN_SHR:  begin fullRes[W-1:0] = shrExt[W:1]; cFlag = shrExt[0]; end
      FN_SAR:  begin fullRes[W-1:0] = sarExt[W:1]; cFlag = sarExt[0]; end
      FN_LDLO: fullRes[W-1:0] = {{LOW{immVal[IMMW-1]}}, immVal};
      FN_LDHI: fullRes[W-1:0] = {immVal, opA[LOW-1:0]};
      default: fullRes = '0;
    endcase
  end

  assign result = fullRes[W-1:0];

  always_comb begin
    statusOut = statusIn;
    if (strobe.flagMode != FM_NONE) begin
      statusOut[ZBIT] = (fullRes[W-1:0] == '0);
      statusOut[NBIT] = fullRes[W-1];
      if (strobe.flagMode == FM_ARITH) statusOut[CBIT] = cFlag;
    end
  end

endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
  import alu_flag_pkg::*;
#(
  parameter int W    = 16,
  parameter int IMMW = 8,
  parameter int OPW  = 5
)(
  input  logic [OPW-1:0]  opSel,
  input  logic [W-1:0]    opA,
  input  logic [W-1:0]    opB,
  input  logic [IMMW-1:0] immVal,
  input  logic [W-1:0]    statusIn,
  output logic [W-1:0]    result,
  output logic [W-1:0]    statusOut,
  output logic            resWrite
);

  aluStrobe_t strobe;

  alu_flag_ctrl u_ctrl (
    .opSel  (opSel),
    .immDir (immVal[3]),
    .strobe (strobe)
  );

  alu_flag_dp #(.W(W), .IMMW(IMMW)) u_dp (
    .strobe    (strobe),
    .opA       (opA),
    .opB       (opB),
    .immVal    (immVal),
    .statusIn  (statusIn),
    .result    (result),
    .statusOut (statusOut)
  );

  assign resWrite = strobe.writeRes;

endmodule

// File: rtl/alu_flag_chk.sv
module alu_flag_chk (
  input logic [4:0]  opSel,
  input logic [15:0] opA,
  input logic [15:0] opB,
  input logic [7:0]  immVal,
  input logic [15:0] statusIn,
  input logic [15:0] result,
  input logic [15:0] statusOut,
  input logic        resWrite
);

  logic flagOp;
  logic logicOp;
  logic regShift;

  assign flagOp   = (opSel < 5'd16);
  assign logicOp  = (opSel == 5'd2) || (opSel == 5'd3) || (opSel == 5'd4) ||
                    (opSel == 5'd9) || (opSel == 5'd12) || (opSel == 5'd13);
  assign regShift = (opSel == 5'd5) || (opSel == 5'd6) || (opSel == 5'd7);

  always_comb begin
    a_r2_side_bits: assert ((statusOut & 16'hFFE3) == (statusIn & 16'hFFE3));
    if (flagOp) begin
      a_r2_zero_flag: assert (statusOut[2] == (result == 16'h0));
      a_r2_neg_flag:  assert (statusOut[4] == result[15]);
    end
    if (logicOp) begin
      a_r3_keep_carry: assert (statusOut[3] == statusIn[3]);
    end
    a_r4_write_strobe: assert (resWrite == ((opSel != 5'd10) && (opSel < 5'd18)));
    if (regShift && opB == 16'h0) begin
      a_r5_zero_count: assert (result == opA && !statusOut[3]);
    end
    if (opSel == 5'd17) begin
      a_r10_high_byte: assert (result == {immVal, opA[7:0]} && statusOut == statusIn);
    end
    if (opSel == 5'd16) begin
      a_r10_low_flags: assert (statusOut == statusIn);
    end
    if (opSel >= 5'd18) begin
      a_r11_reserved: assert (result == 16'h0 && statusOut == statusIn);
    end
  end

endmodule

bind alu_flag_unit alu_flag_chk u_chk (.*);

// File: tb/tb_alu_flag_unit.sv
module tb_alu_flag_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  opSel = '0;
  logic [15:0] opA = '0;
  logic [15:0] opB = '0;
  logic [7:0]  immVal = '0;
  logic [15:0] statusIn = '0;
  logic [15:0] result;
  logic [15:0] statusOut;
  logic        resWrite;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  alu_flag_unit dut (
    .opSel(opSel), .opA(opA), .opB(opB), .immVal(immVal),
    .statusIn(statusIn), .result(result), .statusOut(statusOut), .resWrite(resWrite)
  );

  function automatic logic [15:0] sx4(input logic [3:0] v);
    return {{12{v[3]}}, v};
  endfunction

  function automatic logic [32:0] model(input logic [4:0] op, input logic [15:0] a,
      input logic [15:0] b, input logic [7:0] imm, input logic [15:0] sr);
    logic [16:0] t;
    logic [15:0] so;
    logic        w;
    int          mode;
    int          cnt;
    logic        c;
    t = '0; so = sr; w = 1'b1; mode = 0; cnt = 0; c = 1'b0;
    case (op)
      0:  begin t = a + b; mode = 1; end
      1:  begin t = 17'(a) + 17'(b) + 17'(sr[3]); mode = 1; end
      2:  begin t = {1'b0, a & b}; mode = 2; end
      3:  begin t = {1'b0, a | b}; mode = 2; end
      4:  begin t = {1'b0, a ^ b}; mode = 2; end
      8:  begin t = 17'(0) - 17'(a); mode = 1; end
      9:  begin t = {1'b0, ~a}; mode = 2; end
      10: begin t = 17'(a) - 17'(b); mode = 1; w = 1'b0; end
      11: begin t = 17'(a) + 17'((imm[3:0] == 0) ? 16'd8 : sx4(imm[3:0])); mode = 1; end
      12: begin t = {1'b0, a & sx4(imm[3:0])}; mode = 2; end
      13: begin t = {1'b0, a | sx4(imm[3:0])}; mode = 2; end
      16: t = {1'b0, {8{imm[7]}}, imm};
      17: t = {1'b0, imm, a[7:0]};
      5, 6, 7, 14, 15: begin
        int dir;
        mode = 1;
        if (op == 14) begin
          cnt = (imm[2:0] == 0) ? 8 : int'(imm[2:0]);
          dir = imm[3] ? 1 : 0;
        end else if (op == 15) begin
          cnt = (imm[3:0] == 0) ? 16 : int'(imm[3:0]);
          dir = 2;
        end else begin
          cnt = int'(b);
          dir = int'(op) - 5;
        end
        if (cnt == 0) begin t = {1'b0, a}; c = 1'b0; end
        else if (dir == 0) begin
          t[15:0] = (cnt >= 16) ? 16'h0 : (a << cnt);
          c = (cnt <= 16) ? a[16-cnt] : 1'b0;
        end else if (dir == 1) begin
          t[15:0] = (cnt >= 16) ? 16'h0 : (a >> cnt);
          c = (cnt <= 16) ? a[cnt-1] : 1'b0;
        end else begin
          t[15:0] = (cnt >= 16) ? {16{a[15]}} : 16'($signed(a) >>> cnt);
          c = (cnt <= 16) ? a[cnt-1] : a[15];
        end
        t[16] = c;
      end
      default: begin t = '0; w = 1'b0; end
    endcase
    if (mode != 0) begin
      so[2] = (t[15:0] == 0);
      so[4] = t[15];
      if (mode == 1) so[3] = t[16];
    end
    return {t[15:0], so, w};
  endfunction

  task automatic apply(input logic [4:0] op, input logic [15:0] a, input logic [15:0] b,
                       input logic [7:0] imm, input logic [15:0] sr, input string req);
    logic [32:0] exp;
    @(posedge clk);
    opSel = op; opA = a; opB = b; immVal = imm; statusIn = sr;
    @(negedge clk);
    exp = model(op, a, b, imm, sr);
    checks++;
    if ({result, statusOut, resWrite} !== exp) begin
      errors++;
      $display("FAIL %s op=%0d a=%h b=%h imm=%h sr=%h: got res=%h sr=%h wr=%b exp res=%h sr=%h wr=%b",
               req, op, a, b, imm, sr, result, statusOut, resWrite, exp[32:17], exp[16:1], exp[0]);
    end
  endtask

  task automatic expectVal(input logic [15:0] got, input logic [15:0] want, input string req);
    checks++;
    if (got !== want) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, want);
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (2) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state: zero inputs select add of zeros
    expectVal(result, 16'h0, "R1 idle result");
    expectVal(statusOut, 16'h0004, "R2 idle zero flag");

    // directed corners
    apply(5'd0,  16'hFFFF, 16'h0001, 8'h00, 16'h0000, "R2 add carry out and zero");
    apply(5'd1,  16'h1234, 16'h0001, 8'h00, 16'h0008, "R1 adc carry in");
    apply(5'd10, 16'h0003, 16'h0005, 8'h00, 16'h0000, "R4 cmp borrow");
    apply(5'd10, 16'h0005, 16'h0005, 8'h00, 16'hFF08, "R4 cmp equal");
    apply(5'd8,  16'h0000, 16'h0000, 8'h00, 16'h0008, "R4 neg of zero");
    apply(5'd8,  16'h0001, 16'h0000, 8'h00, 16'h0000, "R4 neg nonzero");
    apply(5'd2,  16'hF0F0, 16'h0F0F, 8'h00, 16'h0008, "R3 and keeps carry");
    apply(5'd6,  16'h8001, 16'h0000, 8'h00, 16'h0008, "R5 zero count shr");
    apply(5'd5,  16'h0001, 16'd16,   8'h00, 16'h0000, "R5 shl by 16");
    apply(5'd6,  16'h8000, 16'd16,   8'h00, 16'h0000, "R5 shr by 16");
    apply(5'd6,  16'hFFFF, 16'd17,   8'h00, 16'h0008, "R6 shr by 17");
    apply(5'd5,  16'hFFFF, 16'hFFFF, 8'h00, 16'h0008, "R6 shl huge count");
    apply(5'd7,  16'h8000, 16'd40,   8'h00, 16'h0000, "R6 sar huge count");
    apply(5'd11, 16'h0010, 16'h0000, 8'h00, 16'h0000, "R7 addi zero is 8");
    apply(5'd11, 16'h0010, 16'h0000, 8'h0F, 16'h0000, "R7 addi minus one");
    apply(5'd12, 16'h1234, 16'h0000, 8'h08, 16'h0008, "R8 andi sign extend");
    apply(5'd13, 16'h0000, 16'h0000, 8'h07, 16'h0000, "R8 ori positive");
    apply(5'd14, 16'h00FF, 16'h0000, 8'h00, 16'h0000, "R9 shi left zero is 8");
    apply(5'd14, 16'h8100, 16'h0000, 8'h08, 16'h0000, "R9 shi right zero is 8");
    apply(5'd15, 16'h8000, 16'h0000, 8'h00, 16'h0000, "R9 sari zero is 16");
    apply(5'd15, 16'h8004, 16'h0000, 8'h03, 16'h0000, "R9 sari by 3");
    apply(5'd16, 16'h5555, 16'h0000, 8'h80, 16'h001C, "R10 load low");
    apply(5'd17, 16'h5566, 16'h0000, 8'hA5, 16'h0004, "R10 load high");
    apply(5'd20, 16'h1234, 16'h5678, 8'h12, 16'hABCD, "R11 reserved code");
    apply(5'd31, 16'hFFFF, 16'hFFFF, 8'hFF, 16'h0000, "R11 reserved top code");

    // constrained random
    for (int i = 0; i < 3000; i++) begin
      logic [4:0]  op;
      logic [15:0] b;
      op = ($urandom % 8 == 0) ? 5'($urandom % 32) : 5'($urandom % 18);
      b  = ($urandom % 4 == 0) ? 16'($urandom) : 16'($urandom % 20);
      apply(op, 16'($urandom), b, 8'($urandom), 16'($urandom), "R1-mix random");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule